// File: doc/BRIEF.md
# Download Block Checksum Accumulator

This block keeps the integrity sum for a serial code-download session. While a write-block command streams in, an upstream parser presents each received byte with a tag. The tag says whether the byte belongs to the length field, the load-address field or the payload. The block adds the bytes into a 32-bit block sum, which is seeded with the constant 5 whenever a new block starts. The two length bytes arrive most significant first and count as one 16-bit word, not as two separate bytes.

When the parser closes a block it has accepted, the one's complement of the block sum's low byte is added into a 16-bit running accumulator, which wraps on overflow. A closed block that the parser rejected leaves the accumulator as it was. An init strobe clears the accumulator. When the host later sends its check byte, the block reports in the next cycle whether that byte equals the one's complement of the accumulator's low byte. In the same cycle it presents that low byte, so the response logic can send it back with either verdict.

Top module: `dl_csum_acc`

## Requirements
- R1: After reset, `acc_o` is 0, and `chk_vld_o` and `match_o` are 0.
- R2: `blk_start_i` seeds the block sum with 5 and drops any bytes gathered earlier. A byte strobed in the same cycle as `blk_start_i` is not added. A block closed with no bytes therefore adds 0xFA to the accumulator.
- R3: A byte tagged length (`fld_i` = 0) is weighted by 256 if it is the first length byte of the block and by 1 if it is the second. Any further length byte in the same block is ignored.
- R4: A byte tagged address (`fld_i` = 1) is added to the block sum unweighted.
- R5: A byte tagged payload (`fld_i` = 2) is added to the block sum unweighted, and the block sum wraps at 32 bits.
- R6: A byte tagged 3, or any cycle with `byte_vld_i` low, leaves the block sum unchanged.
- R7: `blk_end_i` with `blk_ok_i` high adds the one's complement of the block sum's low byte to `acc_o`, modulo 2^16, with the result visible in the next cycle. Bytes strobed in the same cycle as `blk_end_i` are not part of that block.
- R8: `blk_end_i` with `blk_ok_i` low leaves `acc_o` unchanged.
- R9: `clr_i` sets `acc_o` to 0 in the next cycle and takes priority over a simultaneous block end.
- R10: One cycle after `chk_vld_i`, `chk_vld_o` pulses high for exactly one cycle. `match_o` is 1 exactly when `chk_byte_i` equaled the bitwise inverse of `acc_o[7:0]`, and `chk_low_o` holds the `acc_o[7:0]` value sampled with the check byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Init strobe that clears the accumulator |
| blk_start_i | input | 1 | Start of a write block, which seeds the block sum |
| byte_vld_i | input | 1 | Received byte strobe |
| fld_i | input | 2 | Field tag: 0 length, 1 address, 2 payload, 3 none |
| byte_i | input | 8 | Received byte |
| blk_end_i | input | 1 | End of a write block |
| blk_ok_i | input | 1 | The block ending now was accepted |
| chk_vld_i | input | 1 | Check byte strobe |
| chk_byte_i | input | 8 | Check byte from the host |
| acc_o | output | 16 | Running accumulator |
| chk_vld_o | output | 1 | Check result valid pulse |
| match_o | output | 1 | Check byte matched |
| chk_low_o | output | 8 | Accumulator low byte captured with the check |

## Verification
On every cycle, the assertions check three things. The accumulator holds its value unless a clear or an accepted block end occurs. A fold adds exactly the inverted low byte of the internal block sum. A block start reseeds that sum to 5. They also tie each check pulse and its verdict to the strobe and accumulator of the cycle before. Only the bench's scenarios show that the tag weighting is right: the high-byte weight on the first length byte, the ignored third length byte and the ignored tag 3. These are visible only through the accumulator value after a fold, so only a full block followed by a fold can expose them. A sweep of all 256 check bytes shows that exactly one value matches.

// File: rtl/dl_csum_pkg.sv
package dl_csum_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {
    FLD_LEN  = 2'd0,
    FLD_ADDR = 2'd1,
    FLD_DATA = 2'd2,
    FLD_NONE = 2'd3
  } fld_e;
endpackage

// File: rtl/dl_csum_blksum.sv
module dl_csum_blksum
  import dl_csum_pkg::*;
#(
  parameter int SUM_W = 32,
  parameter int SEED  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              vld_i,
  input  fld_e              fld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [SUM_W-1:0]  sum_o
);
  localparam int PAD_W = SUM_W - BYTE_W;

  logic [SUM_W-1:0] byte_ext;
  logic [SUM_W-1:0] byte_hi;
  logic [1:0]       len_seen;

  assign byte_ext = {{PAD_W{1'b0}}, byte_i};
  assign byte_hi  = byte_ext << BYTE_W;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      sum_o    <= SUM_W'(SEED);
      len_seen <= 2'd0;
    end else if (vld_i) begin
      case (fld_i)
        FLD_LEN: begin
          if (len_seen == 2'd0) begin
            sum_o    <= sum_o + byte_hi;
            len_seen <= 2'd1;
          end else if (len_seen == 2'd1) begin
            sum_o    <= sum_o + byte_ext;
            len_seen <= 2'd2;
          end
        end
        FLD_ADDR, FLD_DATA: sum_o <= sum_o + byte_ext;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dl_csum_fold.sv
module dl_csum_fold
  import dl_csum_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              end_i,
  input  logic              ok_i,
  input  logic [BYTE_W-1:0] sum_low_i,
  output logic [ACC_W-1:0]  acc_o
);
  localparam int PAD_W = ACC_W - BYTE_W;

  logic [BYTE_W-1:0] inv_low;
  assign inv_low = ~sum_low_i;

  always_ff @(posedge clk) begin
    if (rst || clr_i)
      acc_o <= '0;
    else if (end_i && ok_i)
      acc_o <= acc_o + {{PAD_W{1'b0}}, inv_low};
  end
endmodule

// File: rtl/dl_csum_check.sv
module dl_csum_check
  import dl_csum_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BYTE_W-1:0] acc_low_i,
  output logic              vld_o,
  output logic              match_o,
  output logic [BYTE_W-1:0] low_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o   <= 1'b0;
      match_o <= 1'b0;
      low_o   <= '0;
    end else begin
      vld_o   <= vld_i;
      match_o <= vld_i && (byte_i == ~acc_low_i);
      if (vld_i) low_o <= acc_low_i;
    end
  end
endmodule

// File: rtl/dl_csum_acc.sv
module dl_csum_acc
  import dl_csum_pkg::*;
#(
  parameter int SUM_W = 32,
  parameter int ACC_W = 16,
  parameter int SEED  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              blk_start_i,
  input  logic              byte_vld_i,
  input  logic [1:0]        fld_i,
  input  logic [7:0]        byte_i,
  input  logic              blk_end_i,
  input  logic              blk_ok_i,
  input  logic              chk_vld_i,
  input  logic [7:0]        chk_byte_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              chk_vld_o,
  output logic              match_o,
  output logic [7:0]        chk_low_o
);
  logic [SUM_W-1:0] blk_sum;

  dl_csum_blksum #(.SUM_W(SUM_W), .SEED(SEED)) u_sum (
    .clk     (clk),
    .rst     (rst),
    .start_i (blk_start_i),
    .vld_i   (byte_vld_i),
    .fld_i   (fld_e'(fld_i)),
    .byte_i  (byte_i),
    .sum_o   (blk_sum)
  );

  dl_csum_fold #(.ACC_W(ACC_W)) u_fold (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (clr_i),
    .end_i     (blk_end_i),
    .ok_i      (blk_ok_i),
    .sum_low_i (blk_sum[BYTE_W-1:0]),
    .acc_o     (acc_o)
  );

  dl_csum_check u_chk (
    .clk       (clk),
    .rst       (rst),
    .vld_i     (chk_vld_i),
    .byte_i    (chk_byte_i),
    .acc_low_i (acc_o[BYTE_W-1:0]),
    .vld_o     (chk_vld_o),
    .match_o   (match_o),
    .low_o     (chk_low_o)
  );
endmodule

// File: rtl/dl_csum_acc_chk.sv
module dl_csum_acc_chk #(
  parameter int SUM_W = 32,
  parameter int ACC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_i,
  input logic             blk_start_i,
  input logic             blk_end_i,
  input logic             blk_ok_i,
  input logic             chk_vld_i,
  input logic [7:0]       chk_byte_i,
  input logic [ACC_W-1:0] acc_o,
  input logic             chk_vld_o,
  input logic             match_o,
  input logic [7:0]       chk_low_o,
  input logic [SUM_W-1:0] blk_sum
);
  AST_SEED_ON_START: assert property (@(posedge clk) disable iff (rst)
    blk_start_i |=> blk_sum == SUM_W'(5)); // R2

  AST_FOLD_ADDS_INV: assert property (@(posedge clk) disable iff (rst)
    (blk_end_i && blk_ok_i && !clr_i) |=>
      acc_o == $past(acc_o) + ACC_W'(8'(~$past(blk_sum[7:0])))); // R7

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !(blk_end_i && blk_ok_i)) |=> $stable(acc_o)); // R8

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> acc_o == '0); // R9

  AST_CHK_PULSE: assert property (@(posedge clk) disable iff (rst)
    chk_vld_i |=> chk_vld_o); // R10

  AST_CHK_ONLY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    !chk_vld_i |=> !chk_vld_o && !match_o); // R10

  AST_CHK_VERDICT: assert property (@(posedge clk) disable iff (rst)
    chk_vld_i |=> (match_o == ($past(chk_byte_i) == 8'(~$past(acc_o[7:0]))))
                  && (chk_low_o == $past(acc_o[7:0]))); // R10
endmodule

bind dl_csum_acc dl_csum_acc_chk #(.SUM_W(SUM_W), .ACC_W(ACC_W)) u_acc_chk (
  .clk         (clk),
  .rst         (rst),
  .clr_i       (clr_i),
  .blk_start_i (blk_start_i),
  .blk_end_i   (blk_end_i),
  .blk_ok_i    (blk_ok_i),
  .chk_vld_i   (chk_vld_i),
  .chk_byte_i  (chk_byte_i),
  .acc_o       (acc_o),
  .chk_vld_o   (chk_vld_o),
  .match_o     (match_o),
  .chk_low_o   (chk_low_o),
  .blk_sum     (blk_sum)
);

// File: tb/dl_csum_acc_tb_top.sv
module dl_csum_acc_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_i = 0, blk_start_i = 0, byte_vld_i = 0, blk_end_i = 0, blk_ok_i = 0;
  logic chk_vld_i = 0;
  logic [1:0] fld_i = 0;
  logic [7:0] byte_i = 0, chk_byte_i = 0;
  logic [15:0] acc_o;
  logic chk_vld_o, match_o;
  logic [7:0] chk_low_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] msum;
  logic [15:0] macc;
  int mlen;
  logic [31:0] lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  dl_csum_acc dut_i (
    .clk(clk), .rst(rst), .clr_i(clr_i), .blk_start_i(blk_start_i),
    .byte_vld_i(byte_vld_i), .fld_i(fld_i), .byte_i(byte_i),
    .blk_end_i(blk_end_i), .blk_ok_i(blk_ok_i), .chk_vld_i(chk_vld_i),
    .chk_byte_i(chk_byte_i), .acc_o(acc_o), .chk_vld_o(chk_vld_o),
    .match_o(match_o), .chk_low_o(chk_low_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every task starts just after a negedge and returns just after a negedge
  task automatic start_blk();
    blk_start_i = 1;
    @(negedge clk);
    blk_start_i = 0;
    msum = 32'd5;
    mlen = 0;
  endtask

  task automatic put(input logic [1:0] f, input logic [7:0] b);
    byte_vld_i = 1; fld_i = f; byte_i = b;
    @(negedge clk);
    byte_vld_i = 0;
    case (f)
      2'd0: begin
        if (mlen == 0) msum = msum + {16'd0, b, 8'd0};
        else if (mlen == 1) msum = msum + {24'd0, b};
        if (mlen < 2) mlen++;
      end
      2'd1, 2'd2: msum = msum + {24'd0, b};
      default: ;
    endcase
  endtask

  task automatic end_blk(input logic ok);
    blk_end_i = 1; blk_ok_i = ok;
    @(negedge clk);
    blk_end_i = 0; blk_ok_i = 0;
    if (ok) macc = macc + {8'd0, ~msum[7:0]};
  endtask

  task automatic do_clr();
    clr_i = 1;
    @(negedge clk);
    clr_i = 0;
    macc = 16'd0;
  endtask

  task automatic do_chk(input logic [7:0] v);
    chk_vld_i = 1; chk_byte_i = v;
    @(negedge clk);
    chk_vld_i = 0;
  endtask

  function automatic logic [7:0] rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg[23:16];
  endfunction

  task automatic full_blk(input int n, input logic ok);
    logic [15:0] len;
    len = 16'(n);
    start_blk();
    put(2'd0, len[15:8]);
    put(2'd0, len[7:0]);
    for (int a = 0; a < 4; a++) put(2'd1, rnd());
    for (int p = 0; p < n; p++) put(2'd2, rnd());
    end_blk(ok);
  endtask

  initial begin
    macc = 0; msum = 5; mlen = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 acc", acc_o, 0);
    check("R1 chk_vld", chk_vld_o, 0);
    check("R1 match", match_o, 0);

    // R2 empty block
    start_blk();
    end_blk(1);
    check("R2 empty block", acc_o, 16'h00FA);

    // R2 byte in same cycle as start is dropped
    byte_vld_i = 1; fld_i = 2'd2; byte_i = 8'h33;
    blk_start_i = 1;
    @(negedge clk);
    byte_vld_i = 0; blk_start_i = 0;
    msum = 5; mlen = 0;
    end_blk(1);
    check("R2 start drops byte", acc_o, macc);

    // R3 length weighting: first byte high, second low, third ignored
    do_clr();
    start_blk();
    put(2'd0, 8'h01); put(2'd0, 8'h02); put(2'd0, 8'h40);
    end_blk(1);
    check("R3 length word", acc_o, 16'h00F8);

    // R4 address bytes
    do_clr();
    start_blk();
    put(2'd1, 8'h10); put(2'd1, 8'h20); put(2'd1, 8'h30); put(2'd1, 8'h40);
    end_blk(1);
    check("R4 address", acc_o, macc);

    // R6 tag 3 and idle cycles ignored
    do_clr();
    start_blk();
    put(2'd3, 8'h77);
    byte_vld_i = 0; fld_i = 2'd2; byte_i = 8'h55;
    @(negedge clk);
    end_blk(1);
    check("R6 ignored bytes", acc_o, 16'h00FA);

    // R7 byte with end is not included
    do_clr();
    start_blk();
    byte_vld_i = 1; fld_i = 2'd2; byte_i = 8'h09; blk_end_i = 1; blk_ok_i = 1;
    @(negedge clk);
    byte_vld_i = 0; blk_end_i = 0; blk_ok_i = 0;
    macc = macc + {8'd0, ~msum[7:0]};
    check("R7 byte at end excluded", acc_o, macc);

    // R8 rejected block
    full_blk(5, 1'b0);
    check("R8 reject holds", acc_o, macc);

    // R9 clear wins over end
    full_blk(3, 1'b1);
    clr_i = 1; blk_end_i = 1; blk_ok_i = 1;
    @(negedge clk);
    clr_i = 0; blk_end_i = 0; blk_ok_i = 0; macc = 0;
    check("R9 clear priority", acc_o, 0);

    // R5 R7 many blocks to wrap both sums
    for (int k = 0; k < 320; k++) begin
      full_blk(k % 9, 1'b1);
      check("R5 R7 block fold", acc_o, macc);
    end
    start_blk();
    put(2'd0, 8'hFF); put(2'd0, 8'hFF);
    for (int p = 0; p < 40; p++) put(2'd2, 8'hFF);
    end_blk(1);
    check("R5 large block", acc_o, macc);

    // R10 sweep all check bytes
    for (int v = 0; v < 256; v++) begin
      do_chk(8'(v));
      check("R10 vld pulse", chk_vld_o, 1);
      check("R10 match", match_o, (8'(v) == ~macc[7:0]) ? 1 : 0);
      check("R10 low byte", chk_low_o, macc[7:0]);
      if (v == 0) begin
        @(negedge clk);
        check("R10 single pulse", chk_vld_o, 0);
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule